// File: doc/BRIEF.md
# Three-Wire Serial Control Register Port

This block takes configuration words from a host microcontroller over three wires: a serial data line, a bit clock and a latch strobe. A level-sensitive enable input decides whether the port listens. Each rising bit-clock edge shifts one data bit into a 12-bit serial-to-parallel register. A rising edge on the latch strobe then copies the word into one of two holding registers. The bit that was shifted in first picks the target.

The two holding registers are an 11-bit attenuation value and a set of seven individual mode flags. Their contents drive the outputs continuously. Each register also has a one-cycle update pulse, so downstream logic knows when a new setting has arrived. All three serial pins are asynchronous to the system clock. Each passes through a two-flop synchronizer, and edges are found by comparing successive synchronized samples.

Top module: `serctl_top`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `attnLevel`, `modeFlags`, `attnUpd` and `flagUpd` are all zero. The shift register is also cleared to zero.
- R2: A data bit is captured only on a rising edge of `serClk`. A change on `serData` while `serClk` is high has no effect on the captured word.
- R3: If the first of the 12 word bits is 0, a latch loads bits 2 to 12 into `attnLevel`. Bit 2 goes to `attnLevel[10]` and bit 12 goes to `attnLevel[0]`.
- R4: If the first word bit is 1, a latch loads bits 6 to 12 into `modeFlags`, one bit per flag:

  | Word bit | Output bit | Flag |
  |----------|------------|------|
  | 6 | `modeFlags[6]` | test 1 |
  | 7 | `modeFlags[5]` | test 2 |
  | 8 | `modeFlags[4]` | rate |
  | 9 | `modeFlags[3]` | 12 dB |
  | 10 | `modeFlags[2]` | rate select 1 |
  | 11 | `modeFlags[1]` | rate select 2 |
  | 12 | `modeFlags[0]` | de-emphasis |

  Bits 2 to 5 are ignored.
- R5: Registers load only on a rising edge of `serLatch`. Holding the strobe high, or letting it fall, changes nothing.
- R6: When more than 12 bits arrive before a latch, only the last 12 bits count.
- R7: When fewer than 12 bits arrive before a latch, the latch uses the current shift-register contents. These include bits left over from earlier words.
- R8: Loading one register leaves the other register unchanged.
- R9: While `portEn` is low, the port ignores bit-clock and strobe edges. The shift register and both holding registers keep their values.
- R10: Each load produces a pulse exactly one cycle long on that register's update output (`attnUpd` or `flagUpd`). The pulse appears in the same cycle in which the new value first shows on the outputs. The other update output stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| portEn | input | 1 | Serial port enable (synchronous level) |
| serData | input | 1 | Serial data, asynchronous |
| serClk | input | 1 | Serial bit clock, asynchronous |
| serLatch | input | 1 | Latch strobe, asynchronous |
| attnLevel | output | 11 | Attenuation register contents |
| modeFlags | output | 7 | Mode-flag register contents |
| attnUpd | output | 1 | One-cycle pulse when the attenuation register loads |
| flagUpd | output | 1 | One-cycle pulse when the flag register loads |

## Verification
The assertions assume that `portEn` is synchronous to `clk`. They also assume that each serial pin stays at a level for at least one system-clock cycle; a pulse too narrow to be sampled could otherwise slip through unseen. The bench drives every input on the falling system-clock edge and holds each bit-clock and strobe level for several cycles. It changes data only while the bit clock is low, except in the deliberate test that changes data while the bit clock is high.

// File: rtl/serctl_pkg.sv
package serctl_pkg;
  parameter int WORD_W = 12;
  parameter int ATTN_W = 11;
  parameter int FLAG_N = 7;
  parameter int SYNC_STAGES = 2;

  typedef struct packed {
    logic shiftEn;
    logic latchEn;
    logic bitVal;
  } ctlStrobe_t;
endpackage

// File: rtl/serctl_ctrl.sv
module serctl_ctrl
  import serctl_pkg::*;
#(
  parameter int STAGES = SYNC_STAGES
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       portEn,
  input  logic       serData,
  input  logic       serClk,
  input  logic       serLatch,
  output ctlStrobe_t strobes
);
  localparam int PINS = 3;
  localparam int LAST = STAGES - 1;
  localparam int I_DAT = 0;
  localparam int I_CLK = 1;
  localparam int I_LAT = 2;

  logic [STAGES-1:0][PINS-1:0] syncChain;
  logic [PINS-1:0] prevSample;
  logic [PINS-1:0] curSample;
  logic [PINS-1:0] riseSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncChain  <= '0;
      prevSample <= '0;
    end else begin
      syncChain  <= {syncChain[STAGES-2:0], {serLatch, serClk, serData}};
      prevSample <= syncChain[LAST];
    end
  end

  assign curSample = syncChain[LAST];
  assign riseSeen  = curSample & ~prevSample;

  always_comb begin
    strobes.shiftEn = portEn & riseSeen[I_CLK];
    strobes.latchEn = portEn & riseSeen[I_LAT];
    strobes.bitVal  = curSample[I_DAT];
  end
endmodule

// File: rtl/serctl_datapath.sv
module serctl_datapath
  import serctl_pkg::*;
#(
  parameter int W_WORD = WORD_W,
  parameter int W_ATTN = ATTN_W,
  parameter int N_FLAG = FLAG_N
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobes,
  output logic [W_ATTN-1:0] attnLevel,
  output logic [N_FLAG-1:0] modeFlags,
  output logic              attnUpd,
  output logic              flagUpd
);
  localparam int SEL_IDX = W_WORD - 1;

  logic [W_WORD-1:0] shiftReg;
  logic              selFlags;
  logic              loadAttn;
  logic              loadFlags;

  assign selFlags  = shiftReg[SEL_IDX];
  assign loadAttn  = strobes.latchEn & ~selFlags;
  assign loadFlags = strobes.latchEn & selFlags;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
    end else if (strobes.shiftEn) begin
      shiftReg <= {shiftReg[W_WORD-2:0], strobes.bitVal};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      attnLevel <= '0;
      modeFlags <= '0;
      attnUpd   <= 1'b0;
      flagUpd   <= 1'b0;
    end else begin
      attnUpd <= loadAttn;
      flagUpd <= loadFlags;
      if (loadAttn)  attnLevel <= shiftReg[W_ATTN-1:0];
      if (loadFlags) modeFlags <= shiftReg[N_FLAG-1:0];
    end
  end
endmodule

// File: rtl/serctl_top.sv
module serctl_top
  import serctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              portEn,
  input  logic              serData,
  input  logic              serClk,
  input  logic              serLatch,
  output logic [ATTN_W-1:0] attnLevel,
  output logic [FLAG_N-1:0] modeFlags,
  output logic              attnUpd,
  output logic              flagUpd
);
  ctlStrobe_t strobes;

  serctl_ctrl #(.STAGES(SYNC_STAGES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .portEn   (portEn),
    .serData  (serData),
    .serClk   (serClk),
    .serLatch (serLatch),
    .strobes  (strobes)
  );

  serctl_datapath #(.W_WORD(WORD_W), .W_ATTN(ATTN_W), .N_FLAG(FLAG_N)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .attnLevel (attnLevel),
    .modeFlags (modeFlags),
    .attnUpd   (attnUpd),
    .flagUpd   (flagUpd)
  );
endmodule

// File: rtl/serctl_chk.sv
module serctl_chk
  import serctl_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              portEn,
  input logic              serData,
  input logic              serClk,
  input logic              serLatch,
  input logic [ATTN_W-1:0] attnLevel,
  input logic [FLAG_N-1:0] modeFlags,
  input logic              attnUpd,
  input logic              flagUpd
);
  AST_ATTN_ONLY_ON_UPD: assert property (@(posedge clk) disable iff (!rstN)
    (attnLevel != $past(attnLevel)) |-> attnUpd); // R10

  AST_FLAG_ONLY_ON_UPD: assert property (@(posedge clk) disable iff (!rstN)
    (modeFlags != $past(modeFlags)) |-> flagUpd); // R10

  AST_UPD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(attnUpd && flagUpd)); // R8

  AST_ATTN_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    attnUpd |=> !attnUpd); // R10

  AST_FLAG_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    flagUpd |=> !flagUpd); // R10

  AST_DISABLED_NO_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !portEn |=> (!attnUpd && !flagUpd)); // R9

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rstN |=> (attnLevel == '0 && modeFlags == '0 && !attnUpd && !flagUpd)); // R1
endmodule

bind serctl_top serctl_chk u_chk (.*);

// File: tb/serctl_top_tb.sv
module serctl_top_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic portEn = 1'b0;
  logic serData = 1'b0;
  logic serClk = 1'b0;
  logic serLatch = 1'b0;
  logic [10:0] attnLevel;
  logic [6:0]  modeFlags;
  logic        attnUpd;
  logic        flagUpd;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  int attnPulses = 0;
  int flagPulses = 0;

  always #10 clk = ~clk;

  serctl_top u_dut (
    .clk(clk), .rstN(rstN), .portEn(portEn), .serData(serData),
    .serClk(serClk), .serLatch(serLatch), .attnLevel(attnLevel),
    .modeFlags(modeFlags), .attnUpd(attnUpd), .flagUpd(flagUpd)
  );

  // behavioural reference model
  int mShift, mAttn, mFlags;
  bit mUpdA, mUpdF;
  bit dQ[$], cQ[$], lQ[$];

  always @(posedge clk) begin
    if (!rstN) begin
      mShift = 0; mAttn = 0; mFlags = 0; mUpdA = 0; mUpdF = 0;
      dQ = '{0, 0, 0}; cQ = '{0, 0, 0}; lQ = '{0, 0, 0};
    end else begin
      mUpdA = 0; mUpdF = 0;
      if (portEn) begin
        if (lQ[1] && !lQ[2]) begin
          if (((mShift >> 11) & 1) == 0) begin mAttn = mShift & 'h7FF; mUpdA = 1; end
          else begin mFlags = mShift & 'h7F; mUpdF = 1; end
        end
        if (cQ[1] && !cQ[2]) mShift = ((mShift << 1) | int'(dQ[1])) & 'hFFF;
      end
      dQ.push_front(serData); void'(dQ.pop_back());
      cQ.push_front(serClk);  void'(cQ.pop_back());
      lQ.push_front(serLatch); void'(lQ.pop_back());
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (attnUpd) attnPulses++;
    if (flagUpd) flagPulses++;
    if (rstN) begin
      check("R3 model attnLevel", int'(attnLevel), mAttn);
      check("R4 model modeFlags", int'(modeFlags), mFlags);
      check("R10 model attnUpd", int'(attnUpd), int'(mUpdA));
      check("R10 model flagUpd", int'(flagUpd), int'(mUpdF));
    end
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(logic b, bit wobble);
    serData = b; tick(3);
    serClk = 1'b1; tick(1);
    if (wobble) serData = ~b;
    tick(3);
    serClk = 1'b0; tick(1);
  endtask

  task automatic sendBits(logic [15:0] w, int n, bit wobble);
    for (int i = n - 1; i >= 0; i--) sendBit(w[i], wobble);
  endtask

  task automatic latch();
    serLatch = 1'b1; tick(4);
    serLatch = 1'b0; tick(4);
  endtask

  initial begin
    int a0, f0;
    tick(3);
    check("R1 attnLevel in reset", int'(attnLevel), 0);
    check("R1 modeFlags in reset", int'(modeFlags), 0);
    rstN = 1'b1; portEn = 1'b1;
    tick(1);
    check("R1 outputs after reset", int'({attnLevel, modeFlags, attnUpd, flagUpd}), 0);

    // R3 attenuation write
    sendBits({4'h0, 1'b0, 11'h5A3}, 12, 0); latch();
    check("R3 attenuation value", int'(attnLevel), 'h5A3);
    check("R10 one attn pulse", attnPulses, 1);
    check("R10 no flag pulse", flagPulses, 0);

    // R4/R8 flag write, bits 2..5 set but ignored
    sendBits({4'h0, 1'b1, 4'b1111, 7'b1010011}, 12, 0); latch();
    check("R4 flag value", int'(modeFlags), 'h53);
    check("R8 attn unchanged", int'(attnLevel), 'h5A3);
    check("R10 one flag pulse", flagPulses, 1);

    // R2 data changes while bit clock high
    sendBits({4'h0, 1'b0, 11'h36C}, 12, 1); latch();
    check("R2 rising edge capture", int'(attnLevel), 'h36C);
    check("R8 flags unchanged", int'(modeFlags), 'h53);

    // R6 more than 12 bits
    sendBits({3'b111, 1'b0, 11'h123}, 15, 0); latch();
    check("R6 last 12 bits", int'(attnLevel), 'h123);

    // R7 short word uses leftover bits: 0x7FF word then 0101 -> 0xFF5
    sendBits({4'h0, 1'b0, 11'h7FF}, 12, 0); latch();
    sendBits(16'h0005, 4, 0); latch();
    check("R7 partial word flags", int'(modeFlags), 'h75);
    check("R7 attn kept", int'(attnLevel), 'h7FF);

    // R5 strobe held high then falls with bits shifting meanwhile
    sendBits({4'h0, 1'b0, 11'h0AB}, 12, 0);
    serLatch = 1'b1; tick(4);
    a0 = attnPulses;
    sendBits({4'h0, 1'b0, 11'h444}, 12, 0);
    serLatch = 1'b0; tick(6);
    check("R5 load on rise only", int'(attnLevel), 'h0AB);
    check("R5 no extra pulse", attnPulses, a0);

    // R9 disabled port
    sendBits({4'h0, 1'b0, 11'h2AA}, 12, 0);
    portEn = 1'b0; tick(2);
    a0 = attnPulses; f0 = flagPulses;
    sendBits({4'h0, 1'b1, 11'h001}, 12, 0); latch();
    check("R9 attn held", int'(attnLevel), 'h0AB);
    check("R9 no pulses", attnPulses + flagPulses, a0 + f0);
    portEn = 1'b1; tick(2);
    latch();
    check("R9 shift reg held", int'(attnLevel), 'h2AA);

    tick(5);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule